// File: doc/BRIEF.md
# Clock Domain Gating Mode Controller

This controller sits beside a processor core and decides, every cycle, which of five clock domains may tick: the core, the data cache, the coherence snoop logic, the time base/decrementer and the peripherals. Each domain gets one registered enable bit, which a downstream gating cell uses. A second output tells the clock source whether the incoming reference clock should still be accepted. A third output is a one-cycle reset pulse for the peripherals.

Software chooses a low-power mode by writing a 3-bit mode code. The mode is entered when a request arrives and its arm bit is set. There are two request paths: an external pin with its own arm bit, and an instruction strobe with its own arm bit. The graded modes differ in which domains stay alive. In one mode the core is slowed to one tick in every four bus cycles while the other domains keep running. Mode changes wait for the end of a slowed core pulse. A wake interrupt or a reset brings every domain back at once.

Top module: `clkgate_mode_ctrl`

## Requirements
- R1: While reset is high, and on the cycle after it, all five enables are 1, `osc_run` is 1 and `periph_rst` is 0. Reset can also be applied in the middle of operation.
- R2: A request is taken only when `pin_req` and `pin_arm` are both 1, or when `sw_req` and `sw_arm` are both 1. A strobe whose arm bit is clear is ignored, and so is an arm bit set without a strobe. An ignored request leaves the enables unchanged.
- R3: Code 1 (doze) leaves only the data cache, snoop and time base enabled: `dom_en` = 5'b01110. The bit order is core=0, dcache=1, snoop=2, time base=3, peripherals=4.
- R4: Code 2 (nap) leaves only the time base enabled: `dom_en` = 5'b01000.
- R5: Code 3 (deep sleep) clears every enable and drops `osc_run`. `osc_run` is 0 only when every enable is 0.
- R6: Code 4 (reduced speed) keeps bits 4..1 at 1. The core bit is 1 on exactly one cycle in every four. Its first 1 appears on the fourth cycle after entry.
- R7: Code 5 (peripheral idle) stops the CPU domains and keeps the peripherals running: `dom_en` = 5'b10000.
- R8: Code 6 (standby) clears every enable and keeps `osc_run` at 1. On entry from any other mode, `periph_rst` is 1 for exactly one cycle, the cycle on which the enables first read 0. Re-requesting standby while already in standby gives no new pulse.
- R9: `wake_irq` forces code 0 (full run). On the next cycle all enables and `osc_run` are 1. A wake in the same cycle as a request wins over the request, and it also discards any request that is pending.
- R10: In reduced speed, a request is applied only at the clock edge that ends a core pulse. A request that arrives earlier is held pending, and the core pulse pattern continues unbroken until that edge.
- R11: Code 7 is reserved. A qualified request that carries code 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Requested mode code from the control register |
| pin_req | input | 1 | External power-down request pin |
| pin_arm | input | 1 | Control bit that allows the pin path |
| sw_req | input | 1 | One-cycle strobe from the power-down instruction |
| sw_arm | input | 1 | Control bit that allows the instruction path |
| wake_irq | input | 1 | Wake-up interrupt |
| dom_en | output | 5 | Per-domain clock enables (core, dcache, snoop, time base, peripherals) |
| osc_run | output | 1 | Keep accepting the reference clock |
| periph_rst | output | 1 | One-cycle peripheral reset on standby entry |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `wake_irq` is sampled as a clean synchronous level, so a wake seen at one edge must show its effect at the next edge. The bench holds reset from time zero and drives every input on the falling edge, so each input is stable across the rising edge that samples it. The reduced-speed and pending-request cases are driven at chosen points of the divide-by-four phase, so that both cases occur: a request that lands on a boundary and one that lands off it.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  localparam int NUM_DOM = 5;

  localparam int DOM_CORE  = 0;
  localparam int DOM_DC    = 1;
  localparam int DOM_SNOOP = 2;
  localparam int DOM_TBASE = 3;
  localparam int DOM_PERI  = 4;

  typedef enum logic [2:0] {
    PM_RUN     = 3'd0,
    PM_DOZE    = 3'd1,
    PM_NAP     = 3'd2,
    PM_SLEEP   = 3'd3,
    PM_REDUCED = 3'd4,
    PM_PIDLE   = 3'd5,
    PM_STANDBY = 3'd6,
    PM_RSVD    = 3'd7
  } pmode_e;

  // Domains allowed to tick in each mode (the core bit of the reduced
  // mode is further qualified by the divider tick).
  function automatic logic [NUM_DOM-1:0] dom_mask(pmode_e m);
    logic [NUM_DOM-1:0] v;
    v = '0;
    case (m)
      PM_RUN, PM_REDUCED: v = '1;
      PM_DOZE: begin
        v[DOM_DC]    = 1'b1;
        v[DOM_SNOOP] = 1'b1;
        v[DOM_TBASE] = 1'b1;
      end
      PM_NAP:   v[DOM_TBASE] = 1'b1;
      PM_PIDLE: v[DOM_PERI]  = 1'b1;
      default:  v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/gate_req_qual.sv
module gate_req_qual
  import clkgate_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wake,
  input  logic   boundary,
  input  logic [2:0] mode_sel,
  input  logic   pin_req,
  input  logic   pin_arm,
  input  logic   sw_req,
  input  logic   sw_arm,
  output logic   apply,
  output pmode_e apply_mode
);

  logic   req_now;
  logic   cand_v;
  pmode_e cand_m;
  logic   pend_v;
  pmode_e pend_m;

  always_comb begin
    req_now = ((pin_req & pin_arm) | (sw_req & sw_arm)) &&
              (pmode_e'(mode_sel) != PM_RSVD);
    cand_v  = req_now | pend_v;
    cand_m  = req_now ? pmode_e'(mode_sel) : pend_m;
    apply   = cand_v & boundary & ~wake;
    apply_mode = cand_m;
  end

  always_ff @(posedge clk) begin
    if (rst || wake) begin
      pend_v <= 1'b0;
      pend_m <= PM_RUN;
    end else if (cand_v && !boundary) begin
      pend_v <= 1'b1;
      pend_m <= cand_m;
    end else if (apply) begin
      pend_v <= 1'b0;
    end
  end

endmodule

// File: rtl/gate_div.sv
module gate_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic restart,
  output logic tick_next,
  output logic at_last
);

  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!active || restart)
      cnt_d = '0;
    else if (cnt_q == LAST)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
    tick_next = active && (cnt_d == LAST);
    at_last   = (cnt_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/gate_en_map.sv
module gate_en_map
  import clkgate_pkg::*;
(
  input  pmode_e             mode,
  input  logic               core_tick,
  output logic [NUM_DOM-1:0] en,
  output logic               osc
);

  always_comb begin
    en = dom_mask(mode);
    if (mode == PM_REDUCED) en[DOM_CORE] = core_tick;
    osc = (mode != PM_SLEEP);
  end

endmodule

// File: rtl/clkgate_mode_ctrl.sv
module clkgate_mode_ctrl
  import clkgate_pkg::*;
#(
  parameter int DIV_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         mode_sel,
  input  logic               pin_req,
  input  logic               pin_arm,
  input  logic               sw_req,
  input  logic               sw_arm,
  input  logic               wake_irq,
  output logic [NUM_DOM-1:0] dom_en,
  output logic               osc_run,
  output logic               periph_rst
);

  pmode_e             mode_q;
  pmode_e             mode_d;
  pmode_e             apply_mode;
  logic               apply;
  logic               boundary;
  logic               tick_next;
  logic               at_last;
  logic               restart;
  logic [NUM_DOM-1:0] en_d;
  logic               osc_d;

  assign boundary = (mode_q != PM_REDUCED) || at_last;

  gate_req_qual u_qual (
    .clk       (clk),
    .rst       (rst),
    .wake      (wake_irq),
    .boundary  (boundary),
    .mode_sel  (mode_sel),
    .pin_req   (pin_req),
    .pin_arm   (pin_arm),
    .sw_req    (sw_req),
    .sw_arm    (sw_arm),
    .apply     (apply),
    .apply_mode(apply_mode)
  );

  always_comb begin
    if (wake_irq)   mode_d = PM_RUN;
    else if (apply) mode_d = apply_mode;
    else            mode_d = mode_q;
    restart = (mode_d == PM_REDUCED) && (mode_q != PM_REDUCED);
  end

  gate_div #(.DIV(DIV_RATIO)) u_div (
    .clk      (clk),
    .rst      (rst),
    .active   (mode_d == PM_REDUCED),
    .restart  (restart),
    .tick_next(tick_next),
    .at_last  (at_last)
  );

  gate_en_map u_map (
    .mode     (mode_d),
    .core_tick(tick_next),
    .en       (en_d),
    .osc      (osc_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= PM_RUN;
      dom_en     <= '1;
      osc_run    <= 1'b1;
      periph_rst <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      dom_en     <= en_d;
      osc_run    <= osc_d;
      periph_rst <= (mode_d == PM_STANDBY) && (mode_q != PM_STANDBY);
    end
  end

endmodule

// File: rtl/clkgate_mode_ctrl_chk.sv
module clkgate_mode_ctrl_chk
  import clkgate_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               wake_irq,
  input logic [NUM_DOM-1:0] dom_en,
  input logic               osc_run,
  input logic               periph_rst
);

  assert_reset_run_R1: assert property (@(posedge clk)
    rst |=> (dom_en == '1 && osc_run && !periph_rst));

  assert_wake_all_on_R9: assert property (@(posedge clk) disable iff (rst)
    wake_irq |=> (dom_en == '1 && osc_run));

  assert_osc_off_all_off_R5: assert property (@(posedge clk) disable iff (rst)
    !osc_run |-> (dom_en == '0));

  assert_prst_single_R8: assert property (@(posedge clk) disable iff (rst)
    periph_rst |=> !periph_rst);

  assert_prst_in_standby_R8: assert property (@(posedge clk) disable iff (rst)
    periph_rst |-> (dom_en == '0 && osc_run));

endmodule

bind clkgate_mode_ctrl clkgate_mode_ctrl_chk u_chk (.*);

// File: tb/clkgate_mode_ctrl_tb.sv
`timescale 1ns/1ps
module clkgate_mode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_sel = '0;
  logic       pin_req = 0, pin_arm = 0, sw_req = 0, sw_arm = 0, wake_irq = 0;
  logic [4:0] dom_en;
  logic       osc_run, periph_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  clkgate_mode_ctrl u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .pin_req(pin_req), .pin_arm(pin_arm), .sw_req(sw_req), .sw_arm(sw_arm),
    .wake_irq(wake_irq), .dom_en(dom_en), .osc_run(osc_run),
    .periph_rst(periph_rst)
  );

  // {sel[14:12], pin,pin_arm,sw,sw_arm,irq [11:7], en[6:2], osc[1], prst[0]}
  localparam int NV = 13;
  localparam logic [14:0] VEC [NV] = '{
    {3'd1, 5'b11000, 5'b01110, 1'b1, 1'b0},  // R3 doze via pin
    {3'd2, 5'b00110, 5'b01000, 1'b1, 1'b0},  // R4 nap via strobe
    {3'd0, 5'b00001, 5'b11111, 1'b1, 1'b0},  // R9 wake
    {3'd3, 5'b10000, 5'b11111, 1'b1, 1'b0},  // R2 pin without arm
    {3'd3, 5'b00100, 5'b11111, 1'b1, 1'b0},  // R2 strobe without arm
    {3'd3, 5'b01100, 5'b11111, 1'b1, 1'b0},  // R2 arms crossed
    {3'd3, 5'b11000, 5'b00000, 1'b0, 1'b0},  // R5 deep sleep
    {3'd7, 5'b11000, 5'b00000, 1'b0, 1'b0},  // R11 reserved code
    {3'd5, 5'b00110, 5'b10000, 1'b1, 1'b0},  // R7 peripheral idle
    {3'd1, 5'b11001, 5'b11111, 1'b1, 1'b0},  // R9 wake beats request
    {3'd6, 5'b11000, 5'b00000, 1'b1, 1'b1},  // R8 standby entry pulse
    {3'd6, 5'b11000, 5'b00000, 1'b1, 1'b0},  // R8 no second pulse
    {3'd0, 5'b00001, 5'b11111, 1'b1, 1'b0}   // R9 wake from standby
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R3";
      1: return "R4";
      3, 4, 5: return "R2";
      6: return "R5";
      7: return "R11";
      8: return "R7";
      10, 11: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {en,osc,prst}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [2:0] s, input logic [4:0] c);
    mode_sel = s;
    {pin_req, pin_arm, sw_req, sw_arm, wake_irq} = c;
  endtask

  task automatic idle();
    drive(3'd0, 5'b00000);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    step();
    chk("R1", {dom_en, osc_run, periph_rst}, 7'b1111110);
    rst = 1'b0;
    step();

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14:12], VEC[i][11:7]);
      step();
      chk(vec_tag(i), {dom_en, osc_run, periph_rst}, VEC[i][6:0]);
    end
    idle();
    step();

    // R6: reduced speed, core pulses once per four cycles
    drive(3'd4, 5'b00110);
    step();
    idle();
    for (int k = 0; k < 8; k++) begin
      chk("R6", {dom_en, osc_run, periph_rst},
          {4'b1111, (k % 4 == 3) ? 1'b1 : 1'b0, 1'b1, 1'b0});
      step();
    end
    // now one cycle past a pulse (phase 0); request doze off-boundary: R10
    drive(3'd1, 5'b11000);
    step();
    idle();
    chk("R10", {dom_en, osc_run, periph_rst}, 7'b1111010);
    step();
    chk("R10", {dom_en, osc_run, periph_rst}, 7'b1111010);
    step();
    chk("R10", {dom_en, osc_run, periph_rst}, 7'b1111110);
    step();
    chk("R10", {dom_en, osc_run, periph_rst}, 7'b0111010);

    // R9: wake from reduced speed mid-phase
    drive(3'd4, 5'b11000);
    step();
    idle();
    step();
    drive(3'd0, 5'b00001);
    step();
    idle();
    chk("R9", {dom_en, osc_run, periph_rst}, 7'b1111110);
    step();
    chk("R9", {dom_en, osc_run, periph_rst}, 7'b1111110);

    // R1: reset in the middle of nap
    drive(3'd2, 5'b11000);
    step();
    idle();
    chk("R4", {dom_en, osc_run, periph_rst}, 7'b0100010);
    rst = 1'b1;
    step();
    chk("R1", {dom_en, osc_run, periph_rst}, 7'b1111110);
    rst = 1'b0;
    step();
    chk("R1", {dom_en, osc_run, periph_rst}, 7'b1111110);

    done = 1;
    finish_run();
  end

endmodule